// File: doc/BRIEF.md
# UART Receive Flow Control and Interrupt Combiner

This block holds the auxiliary control logic of one UART channel. It watches the occupancy count of the receive FIFO and, once software has asserted the request-to-send output, takes it away again automatically when the FIFO reaches a programmed quarter, half or three-quarter fill mark. The automatic path only ever negates the output. Turning it back on always takes a fresh software write.

The block also watches the clear-to-send pin for level changes in either direction. When change detection is enabled, a change latches a change-of-state status bit, which software clears by writing one to it. That bit joins seven status bits from the rest of the UART to form an 8-bit status word. The status word is always readable unmasked, and it is ANDed with a mask register to drive one interrupt line.

Writes use a single-cycle port with a 2-bit select. Status is read combinationally from the registered state.

Top module: `uart_flowctl_irq`

## Requirements
- R1: After synchronous reset, rts_n is 1 (negated), rd_status is 0 except the bits that mirror src_status, irq is 0, and the fill-mark control is disabled.
- R2: A write with wr_sel=2 and wr_data[0]=1 asserts RTS, and rts_n reads 0 after that clock edge. With fill-mark control disabled, RTS then stays asserted whatever fifo_count is.
- R3: The fill-mark field is bits [2:1] of the auxiliary control register, written with wr_sel=0. A value of 1, 2 or 3 negates RTS on the edge after fifo_count >= FIFO_DEPTH*value/4, which is 4, 8 or 12 at depth 16. A count below the mark leaves RTS asserted.
- R4: Once the fill-mark logic has negated RTS, it stays negated after fifo_count falls, until software writes wr_sel=2 with bit 0 set again.
- R5: While tx_rts_en is 1, fill-mark control is disabled even with a nonzero field, so RTS stays asserted.
- R6: A set write that arrives in the same cycle as an active fill-mark condition leaves RTS negated.
- R7: With the change-enable bit (bit 0 of the auxiliary control register) at 1, any level change on cts_n sets rd_status[7] on the third rising edge after the change. Both edges of cts_n count.
- R8: With the change-enable bit at 0, a cts_n change leaves rd_status[7] at 0.
- R9: A write with wr_sel=3 and wr_data[7]=1 clears rd_status[7]. A new change detected in that same cycle wins, and the bit stays 1.
- R10: rd_status[6:0] follows src_status whatever the mask is. irq is 1 exactly when some bit of rd_status and the same bit of the mask register (written with wr_sel=1) are both 1.
- R11: Bits [7:3] of an auxiliary control write are discarded, so writing 0xF8 leaves fill-mark control disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 aux control, 1 mask, 2 RTS set, 3 change clear |
| wr_data | input | 8 | Write data |
| rd_status | output | 8 | Status word, bit 7 change-of-state |
| fifo_count | input | CNT_W | Receive FIFO occupancy |
| tx_rts_en | input | 1 | Transmitter-side RTS mode active |
| src_status | input | 7 | Other UART status sources |
| cts_n | input | 1 | Clear-to-send pin, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq | output | 1 | Masked interrupt request |

## Verification
The checker assumes that fifo_count, tx_rts_en and the write port only change away from the rising edge and are valid at it. It also assumes cts_n rests high through reset, so that the synchroniser's reset value does not look like a change. The bench drives every input on the falling edge, holds cts_n high until reset is released, and only toggles cts_n once the previous change has settled through the synchroniser.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [1:0] {
        SEL_AUX    = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_RTSSET = 2'd2,
        SEL_COSCLR = 2'd3
    } fc_sel_e;

    typedef enum logic [1:0] {
        MARK_OFF = 2'd0,
        MARK_Q1  = 2'd1,
        MARK_Q2  = 2'd2,
        MARK_Q3  = 2'd3
    } fill_mark_e;

    typedef struct packed {
        fill_mark_e mark;
        logic       chg_en;
    } aux_ctrl_t;

    localparam int STAT_W  = 8;
    localparam int COS_BIT = STAT_W - 1;

    // occupancy at which the given quarter mark is reached
    function automatic int unsigned mark_level(int unsigned depth, fill_mark_e m);
        return (depth * int'(m)) / 4;
    endfunction

endpackage

// File: rtl/fc_cts_detect.sv
module fc_cts_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic change
);
    // SYNC_STAGES synchroniser flops plus one history flop
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[SYNC_STAGES-1:0], pin_n};
    end

    assign change = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fill_mark_e       mark,
    input  logic             tx_rts_en,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             sw_set,
    output logic             rts_n
);
    logic             asserted_q;
    logic [CNT_W-1:0] level;
    logic             auto_neg;

    always_comb begin
        level    = CNT_W'(mark_level(FIFO_DEPTH, mark));
        auto_neg = (mark != MARK_OFF) && !tx_rts_en && (fifo_count >= level);
    end

    always_ff @(posedge clk) begin
        if (rst)           asserted_q <= 1'b0;
        else if (auto_neg) asserted_q <= 1'b0;
        else if (sw_set)   asserted_q <= 1'b1;
    end

    assign rts_n = ~asserted_q;
endmodule

// File: rtl/fc_status_irq.sv
module fc_status_irq
    import uart_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_change,
    input  logic              chg_en,
    input  logic              cos_clr,
    input  logic [STAT_W-2:0] src_status,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic cos_q;

    always_ff @(posedge clk) begin
        if (rst)                       cos_q <= 1'b0;
        else if (cts_change && chg_en) cos_q <= 1'b1;
        else if (cos_clr)              cos_q <= 1'b0;
    end

    always_comb begin
        status = {cos_q, src_status};
        irq    = |(status & mask);
    end
endmodule

// File: rtl/uart_flowctl_irq.sv
module uart_flowctl_irq
    import uart_fc_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_status,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             tx_rts_en,
    input  logic [6:0]       src_status,
    input  logic             cts_n,
    output logic             rts_n,
    output logic             irq
);
    aux_ctrl_t         aux_q;
    logic [STAT_W-1:0] mask_q;
    fc_sel_e           sel;
    logic              rts_set;
    logic              cos_clr;
    logic              cts_change;

    assign sel     = fc_sel_e'(wr_sel);
    assign rts_set = wr_en && (sel == SEL_RTSSET) && wr_data[0];
    assign cos_clr = wr_en && (sel == SEL_COSCLR) && wr_data[COS_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_AUX)  aux_q  <= aux_ctrl_t'(wr_data[2:0]);
            if (sel == SEL_MASK) mask_q <= wr_data;
        end
    end

    fc_rts_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rts (
        .clk        (clk),
        .rst        (rst),
        .mark       (aux_q.mark),
        .tx_rts_en  (tx_rts_en),
        .fifo_count (fifo_count),
        .sw_set     (rts_set),
        .rts_n      (rts_n)
    );

    fc_cts_detect #(.SYNC_STAGES(2)) u_cts (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (cts_n),
        .change (cts_change)
    );

    fc_status_irq u_stat (
        .clk        (clk),
        .rst        (rst),
        .cts_change (cts_change),
        .chg_en     (aux_q.chg_en),
        .cos_clr    (cos_clr),
        .src_status (src_status),
        .mask       (mask_q),
        .status     (rd_status),
        .irq        (irq)
    );
endmodule

// File: rtl/uart_flowctl_irq_chk.sv
module uart_flowctl_irq_chk
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [7:0]       wr_data,
    input logic [7:0]       status,
    input logic [7:0]       mask,
    input logic [1:0]       mark,
    input logic             tx_rts_en,
    input logic [CNT_W-1:0] fifo_count,
    input logic [6:0]       src_status,
    input logic             rts_n,
    input logic             irq
);
    logic [CNT_W-1:0] lvl;
    assign lvl = CNT_W'(mark_level(FIFO_DEPTH, fill_mark_e'(mark)));

    p_mark_negates_r3: assert property (@(posedge clk) disable iff (rst)
        (mark != 2'd0 && !tx_rts_en && fifo_count >= lvl) |=> rts_n);

    p_only_sw_asserts_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rts_n) |-> $past(wr_en && wr_sel == 2'd2 && wr_data[0]));

    p_off_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (mark == 2'd0 && !rts_n) |=> !rts_n);

    p_tx_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_rts_en && !rts_n) |=> !rts_n);

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((status & mask) == 8'h00) |-> !irq);

    p_true_status_r10: assert property (@(posedge clk) disable iff (rst)
        status[6:0] == src_status);
endmodule

bind uart_flowctl_irq uart_flowctl_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .status     (rd_status),
    .mask       (mask_q),
    .mark       (aux_q.mark),
    .tx_rts_en  (tx_rts_en),
    .fifo_count (fifo_count),
    .src_status (src_status),
    .rts_n      (rts_n),
    .irq        (irq)
);

// File: tb/uart_flowctl_irq_tb.sv
module uart_flowctl_irq_tb;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_status;
    logic [CW-1:0] fifo_count = '0;
    logic          tx_rts_en = 1'b0;
    logic [6:0]    src_status = '0;
    logic          cts_n = 1'b1;
    logic          rts_n;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    uart_flowctl_irq #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_status(rd_status), .fifo_count(fifo_count), .tx_rts_en(tx_rts_en),
        .src_status(src_status), .cts_n(cts_n), .rts_n(rts_n), .irq(irq)
    );

    // {mark[1:0], tx_rts_en, count[4:0], expected rts_n}
    localparam logic [8:0] VEC [10] = '{
        {2'd1, 1'b0, 5'd3,  1'b0},   // R3 below quarter
        {2'd1, 1'b0, 5'd4,  1'b1},   // R3 at quarter
        {2'd2, 1'b0, 5'd7,  1'b0},   // R3 below half
        {2'd2, 1'b0, 5'd8,  1'b1},   // R3 at half
        {2'd3, 1'b0, 5'd11, 1'b0},   // R3 below three quarters
        {2'd3, 1'b0, 5'd12, 1'b1},   // R3 at three quarters
        {2'd3, 1'b0, 5'd16, 1'b1},   // R3 full
        {2'd0, 1'b0, 5'd16, 1'b0},   // R2 control off
        {2'd3, 1'b1, 5'd16, 1'b0},   // R5 tx side enabled
        {2'd2, 1'b1, 5'd9,  1'b0}    // R5 tx side enabled
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        src_status = 7'h00;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 rts_n", rts_n, 1);
        check("R1 status", rd_status, 8'h00);
        check("R1 irq", irq, 0);
        fifo_count = 5'd16; idle(2);
        check("R1 control off", rts_n, 1);
        wr(2'd2, 8'h01);
        check("R1 mark off after reset", rts_n, 0);
        fifo_count = '0;

        // table of fill-mark cases (R2 R3 R5)
        for (int i = 0; i < 10; i++) begin
            fifo_count = '0;
            tx_rts_en  = VEC[i][6];
            wr(2'd0, {5'b0, VEC[i][8:7], 1'b0});
            wr(2'd2, 8'h01);
            check("R2 set write", rts_n, 0);
            fifo_count = VEC[i][5:1];
            idle(2);
            check($sformatf("R3/R5 vector %0d", i), rts_n, VEC[i][0]);
        end
        tx_rts_en = 1'b0;

        // R4 no self reassertion
        fifo_count = '0;
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h01);
        fifo_count = 5'd4; idle(2);
        check("R4 negated", rts_n, 1);
        fifo_count = 5'd0; idle(3);
        check("R4 stays negated", rts_n, 1);
        wr(2'd2, 8'h01);
        check("R4 sw reassert", rts_n, 0);

        // R6 set write while fill mark active
        fifo_count = 5'd5; idle(1);
        check("R6 negated", rts_n, 1);
        wr(2'd2, 8'h01);
        check("R6 set loses", rts_n, 1);
        fifo_count = '0;

        // R11 reserved bits ignored
        wr(2'd0, 8'hF8);
        wr(2'd2, 8'h01);
        fifo_count = 5'd16; idle(2);
        check("R11 reserved ignored", rts_n, 0);
        fifo_count = '0;

        // R7 change detect, falling edge
        wr(2'd0, 8'h01);
        cts_n = 1'b0;
        idle(2);
        check("R7 not yet", rd_status[7], 0);
        idle(1);
        check("R7 falling edge", rd_status[7], 1);
        wr(2'd3, 8'h80);
        check("R9 cleared", rd_status[7], 0);
        // rising edge
        cts_n = 1'b1; idle(3);
        check("R7 rising edge", rd_status[7], 1);
        wr(2'd3, 8'h80);
        // R9 set wins over clear
        cts_n = 1'b0; idle(2);
        wr(2'd3, 8'h80);
        check("R9 set beats clear", rd_status[7], 1);
        wr(2'd3, 8'h80);
        check("R9 cleared again", rd_status[7], 0);

        // R8 change disabled
        wr(2'd0, 8'h00);
        cts_n = 1'b1; idle(5);
        check("R8 disabled", rd_status[7], 0);

        // R10 masking
        src_status = 7'h05; idle(1);
        check("R10 true status", rd_status, 8'h05);
        check("R10 unmasked quiet", irq, 0);
        wr(2'd1, 8'h04);
        check("R10 masked hit", irq, 1);
        wr(2'd1, 8'h02);
        check("R10 masked miss", irq, 0);
        src_status = 7'h00;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h80);
        cts_n = 1'b0; idle(3);
        check("R10 change irq", irq, 1);
        wr(2'd3, 8'h80);
        check("R10 irq drops", irq, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule